// File: doc/BRIEF.md
# Vectoring Interrupt Controller for a Mode-0 Bus

This block sits beside an 8-bit CPU whose interrupt scheme lets the interrupting device supply a whole instruction. It gathers eight level-sensitive request lines. Each line has its own 16-bit service address, and each can be enabled on its own. The block picks the most urgent eligible request and raises the CPU interrupt line. The CPU then runs its acknowledge cycle, which the block recognises when the opcode-fetch strobe and the I/O strobe are both high. In answer, the block feeds a three-byte subroutine call: the call opcode goes out during the acknowledge, and the two address bytes go out on the next two ordinary memory reads. From the acknowledge until the next real opcode fetch, the block asserts an inhibit that keeps main memory off the data bus.

The block also watches every opcode fetch for the two-byte return-from-interrupt sequence. An input that has been served stays in service until that sequence is seen. While it is in service, that input and every less urgent input are held off, but a more urgent input can still interrupt. Software writes the configuration through a single chip-select, a 4-bit register index and an 8-bit data byte.

All bus strobes are modelled as active-high signals sampled by the block's own clock, which runs faster than the bus. Every output is registered and changes one clock after the strobe that caused it.

Top module: `vcall_intc`

## Requirements
- R1: After reset, int_o, dout_en_o and mem_inhibit_o are 0, and the enable mask is 0, so no request can raise int_o until the mask is written.
- R2: When cfg_cs is high, index 8 loads a shared high-byte staging register. Index k (0..7) sets input k's service address to {staging, cfg_data}. Index 9 loads the enable mask, where bit k enables input k. Nothing is written while cfg_cs is low.
- R3: int_o goes high one clock after a request whose mask bit is set becomes eligible. A request whose mask bit is clear never raises int_o.
- R4: An acknowledge (bus_m1 and bus_iorq both high) that finds an eligible request is answered one clock later with dout_en_o=1 and dout_o=8'hCD. The drive is held while the acknowledge lasts and drops one clock after it ends.
- R5: After an accepted acknowledge, the first memory read (bus_mreq and bus_rd high, bus_m1 and bus_iorq low) is answered with the low byte of the winner's address, and the second with the high byte. A third read is not answered.
- R6: mem_inhibit_o rises one clock after an accepted acknowledge. It falls one clock after the next opcode fetch (bus_m1, bus_mreq and bus_rd high, bus_iorq low).
- R7: Lower index means higher priority. The winner is latched at the acknowledge, so changes on req_i during delivery do not change the address bytes supplied.
- R8: A served input is marked in service. It holds off that input and all higher-numbered inputs, while lower-numbered (more urgent) inputs can still raise int_o.
- R9: Two consecutive opcode fetches carrying 8'hED and then 8'h4D clear the most urgent in-service mark. 8'hED followed by any other byte clears nothing.
- R10: int_o stays low from an accepted acknowledge until the high address byte has been supplied.
- R11: An acknowledge that finds no eligible request is not answered: dout_en_o and mem_inhibit_o stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, faster than the bus |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 8 | Level interrupt requests, bit 0 most urgent |
| cfg_cs | input | 1 | Configuration write strobe |
| cfg_idx | input | 4 | Configuration register index |
| cfg_data | input | 8 | Configuration write data |
| bus_m1 | input | 1 | CPU opcode-fetch strobe (high = active) |
| bus_iorq | input | 1 | CPU I/O request strobe (high = active) |
| bus_mreq | input | 1 | CPU memory request strobe (high = active) |
| bus_rd | input | 1 | CPU read strobe (high = active) |
| bus_din | input | 8 | Data bus as seen by the block, for opcode snooping |
| int_o | output | 1 | Interrupt request to the CPU |
| dout_o | output | 8 | Byte driven onto the data bus |
| dout_en_o | output | 1 | Data bus drive enable |
| mem_inhibit_o | output | 1 | Keeps main memory off the bus |

## Verification
On every cycle the assertions check four things: a drive that follows an acknowledge carries the call opcode; the drive is only ever on in answer to a bus strobe from the cycle before; int_o only rises when some enabled request was present; and any opcode fetch clears the memory inhibit. The directed scenarios show what no single-cycle property can. They confirm that the address bytes go out in low-then-high order from the input latched at the acknowledge, that priority holds across the in-service marks, that only a well-formed return sequence releases those marks, and that configuration writes take effect and ignored ones have no effect.

// File: rtl/vcall_pkg.sv
package vcall_pkg;
    localparam int DATA_W = 8;
    localparam logic [DATA_W-1:0] OP_CALL   = 8'hCD;
    localparam logic [DATA_W-1:0] OP_PREFIX = 8'hED;
    localparam logic [DATA_W-1:0] OP_RETI2  = 8'h4D;
endpackage

// File: rtl/vcall_regs.sv
module vcall_regs
    import vcall_pkg::*;
#(
    parameter int N_IRQ = 8,
    parameter int IDX_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_cs,
    input  logic [IDX_W-1:0]           cfg_idx,
    input  logic [DATA_W-1:0]          cfg_data,
    output logic [N_IRQ*2*DATA_W-1:0]  vec_o,
    output logic [N_IRQ-1:0]           mask_o
);
    localparam int ADDR_W = 2 * DATA_W;
    localparam logic [IDX_W-1:0] IDX_STAGE = IDX_W'(N_IRQ);
    localparam logic [IDX_W-1:0] IDX_MASK  = IDX_W'(N_IRQ + 1);

    typedef struct packed {
        logic [N_IRQ-1:0][ADDR_W-1:0] vec;
        logic [DATA_W-1:0]            stage;
        logic [N_IRQ-1:0]             mask;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        if (cfg_cs) begin
            if (cfg_idx == IDX_STAGE) d.stage = cfg_data;
            if (cfg_idx == IDX_MASK)  d.mask  = cfg_data[N_IRQ-1:0];
            for (int k = 0; k < N_IRQ; k++) begin
                if (cfg_idx == IDX_W'(k)) d.vec[k] = {q.stage, cfg_data};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign vec_o  = q.vec;
    assign mask_o = q.mask;
endmodule

// File: rtl/vcall_prio.sv
module vcall_prio #(
    parameter int N_IRQ = 8,
    parameter int WIN_W = $clog2(N_IRQ)
) (
    input  logic [N_IRQ-1:0] req_i,
    input  logic [N_IRQ-1:0] mask_i,
    input  logic [N_IRQ-1:0] isr_i,
    output logic             any_o,
    output logic [WIN_W-1:0] win_o
);
    logic [N_IRQ-1:0] allowed;
    logic [N_IRQ-1:0] elig;

    // An input may interrupt only if neither it nor a more urgent input is in service.
    for (genvar gi = 0; gi < N_IRQ; gi++) begin : g_allow
        assign allowed[gi] = ~|isr_i[gi:0];
    end

    assign elig  = req_i & mask_i & allowed;
    assign any_o = |elig;

    always_comb begin
        win_o = '0;
        for (int i = N_IRQ - 1; i >= 0; i--) begin
            if (elig[i]) win_o = WIN_W'(i);
        end
    end
endmodule

// File: rtl/vcall_seq.sv
module vcall_seq
    import vcall_pkg::*;
#(
    parameter int N_IRQ = 8,
    parameter int WIN_W = $clog2(N_IRQ)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_m1,
    input  logic                      bus_iorq,
    input  logic                      bus_mreq,
    input  logic                      bus_rd,
    input  logic [DATA_W-1:0]         bus_din,
    input  logic                      elig_any,
    input  logic [WIN_W-1:0]          win_idx,
    input  logic [N_IRQ*2*DATA_W-1:0] vec_i,
    output logic                      irq_o,
    output logic                      drv_o,
    output logic [DATA_W-1:0]         dout_o,
    output logic                      inhibit_o,
    output logic [N_IRQ-1:0]          isr_o
);
    localparam int ADDR_W = 2 * DATA_W;

    typedef struct packed {
        logic              feed;     // call delivery in progress
        logic              hi_next;  // next operand byte is the high byte
        logic [WIN_W-1:0]  win;
        logic [N_IRQ-1:0]  isr;
        logic              drv;
        logic [DATA_W-1:0] dout;
        logic              inhibit;
        logic              seen_pfx;
        logic              ack_p;
        logic              mrd_p;
        logic              fetch_p;
        logic              irq;
    } seq_t;

    seq_t q, d;

    logic ack, mrd, fetch;
    logic [ADDR_W-1:0] tgt;

    assign ack   = bus_m1 & bus_iorq;
    assign mrd   = bus_mreq & bus_rd & ~bus_m1 & ~bus_iorq;
    assign fetch = bus_m1 & bus_mreq & bus_rd & ~bus_iorq;
    assign tgt   = vec_i[int'(q.win)*ADDR_W +: ADDR_W];

    always_comb begin
        d         = q;
        d.ack_p   = ack;
        d.mrd_p   = mrd;
        d.fetch_p = fetch;

        if (!ack && !mrd) d.drv = 1'b0;

        if (ack && !q.ack_p && !q.feed && elig_any) begin
            d.feed    = 1'b1;
            d.hi_next = 1'b0;
            d.win     = win_idx;
            d.isr     = q.isr | (N_IRQ'(1) << win_idx);
            d.drv     = 1'b1;
            d.dout    = OP_CALL;
            d.inhibit = 1'b1;
        end

        if (mrd && !q.mrd_p && q.feed) begin
            d.drv = 1'b1;
            if (!q.hi_next) begin
                d.dout    = tgt[DATA_W-1:0];
                d.hi_next = 1'b1;
            end else begin
                d.dout = tgt[ADDR_W-1:DATA_W];
                d.feed = 1'b0;
            end
        end

        if (fetch && !q.fetch_p) begin
            d.inhibit  = 1'b0;
            d.seen_pfx = (bus_din == OP_PREFIX);
            if (q.seen_pfx && bus_din == OP_RETI2) begin
                d.isr = q.isr & (q.isr - 1'b1);  // drop the most urgent mark
            end
        end

        d.irq = elig_any & ~d.feed;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign irq_o     = q.irq;
    assign drv_o     = q.drv;
    assign dout_o    = q.dout;
    assign inhibit_o = q.inhibit;
    assign isr_o     = q.isr;
endmodule

// File: rtl/vcall_intc.sv
module vcall_intc
    import vcall_pkg::*;
#(
    parameter int N_IRQ = 8,
    parameter int IDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IRQ-1:0]  req_i,
    input  logic              cfg_cs,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [7:0]        cfg_data,
    input  logic              bus_m1,
    input  logic              bus_iorq,
    input  logic              bus_mreq,
    input  logic              bus_rd,
    input  logic [7:0]        bus_din,
    output logic              int_o,
    output logic [7:0]        dout_o,
    output logic              dout_en_o,
    output logic              mem_inhibit_o
);
    localparam int WIN_W  = $clog2(N_IRQ);
    localparam int ADDR_W = 2 * DATA_W;

    logic [N_IRQ*ADDR_W-1:0] vec;
    logic [N_IRQ-1:0]        en_mask;
    logic [N_IRQ-1:0]        isr;
    logic                    elig_any;
    logic [WIN_W-1:0]        win_idx;

    vcall_regs #(.N_IRQ(N_IRQ), .IDX_W(IDX_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .cfg_cs(cfg_cs), .cfg_idx(cfg_idx),
        .cfg_data(cfg_data), .vec_o(vec), .mask_o(en_mask)
    );

    vcall_prio #(.N_IRQ(N_IRQ), .WIN_W(WIN_W)) i_prio (
        .req_i(req_i), .mask_i(en_mask), .isr_i(isr),
        .any_o(elig_any), .win_o(win_idx)
    );

    vcall_seq #(.N_IRQ(N_IRQ), .WIN_W(WIN_W)) i_seq (
        .clk(clk), .rst_n(rst_n), .bus_m1(bus_m1), .bus_iorq(bus_iorq),
        .bus_mreq(bus_mreq), .bus_rd(bus_rd), .bus_din(bus_din),
        .elig_any(elig_any), .win_idx(win_idx), .vec_i(vec),
        .irq_o(int_o), .drv_o(dout_en_o), .dout_o(dout_o),
        .inhibit_o(mem_inhibit_o), .isr_o(isr)
    );
endmodule

// File: rtl/vcall_chk.sv
module vcall_chk #(
    parameter int N_IRQ = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_IRQ-1:0] req_i,
    input logic [N_IRQ-1:0] en_mask,
    input logic             bus_m1,
    input logic             bus_iorq,
    input logic             bus_mreq,
    input logic             bus_rd,
    input logic             int_o,
    input logic [7:0]       dout_o,
    input logic             dout_en_o,
    input logic             mem_inhibit_o
);
    logic ack_c, mrd_c, fetch_c;
    assign ack_c   = bus_m1 & bus_iorq;
    assign mrd_c   = bus_mreq & bus_rd & ~bus_m1 & ~bus_iorq;
    assign fetch_c = bus_m1 & bus_mreq & bus_rd & ~bus_iorq;

    // R4: a drive following an acknowledge carries the call opcode
    p_call_opcode_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_en_o && $past(ack_c)) |-> (dout_o == 8'hCD));

    // R5: the drive is only on in answer to a bus strobe
    p_drive_needs_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en_o |-> $past(ack_c || mrd_c));

    // R3: int_o only follows an enabled request
    p_irq_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int_o |-> $past(|(req_i & en_mask)));

    // R6: an opcode fetch always clears the memory inhibit
    p_inhibit_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_c && !$past(fetch_c)) |=> !mem_inhibit_o);
endmodule

bind vcall_intc vcall_chk #(.N_IRQ(N_IRQ)) i_vcall_chk (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .en_mask(en_mask),
    .bus_m1(bus_m1), .bus_iorq(bus_iorq), .bus_mreq(bus_mreq), .bus_rd(bus_rd),
    .int_o(int_o), .dout_o(dout_o), .dout_en_o(dout_en_o),
    .mem_inhibit_o(mem_inhibit_o)
);

// File: tb/test_vcall_intc.sv
module test_vcall_intc;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req_i = '0;
    logic       cfg_cs = 1'b0;
    logic [3:0] cfg_idx = '0;
    logic [7:0] cfg_data = '0;
    logic       bus_m1 = 1'b0, bus_iorq = 1'b0, bus_mreq = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_din = '0;
    logic       int_o, dout_en_o, mem_inhibit_o;
    logic [7:0] dout_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    vcall_intc i_vcall_intc (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .cfg_cs(cfg_cs),
        .cfg_idx(cfg_idx), .cfg_data(cfg_data), .bus_m1(bus_m1),
        .bus_iorq(bus_iorq), .bus_mreq(bus_mreq), .bus_rd(bus_rd),
        .bus_din(bus_din), .int_o(int_o), .dout_o(dout_o),
        .dout_en_o(dout_en_o), .mem_inhibit_o(mem_inhibit_o)
    );

    function automatic logic [15:0] addr_of(int k);
        return {8'h40 + 8'(k), 8'h10 * 8'(k) + 8'h03};
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg_wr(logic [3:0] idx, logic [7:0] data, logic cs = 1'b1);
        cfg_cs = cs; cfg_idx = idx; cfg_data = data;
        wait_n(1);
        cfg_cs = 1'b0;
    endtask

    task automatic ack_cycle(logic exp_en);
        bus_m1 = 1'b1; bus_iorq = 1'b1;
        wait_n(2);
        chk("R4/R11 drive during acknowledge", 16'(dout_en_o), 16'(exp_en));
        if (exp_en) chk("R4 call opcode", 16'(dout_o), 16'h00CD);
        bus_m1 = 1'b0; bus_iorq = 1'b0;
        wait_n(2);
        chk("R4 drive released", 16'(dout_en_o), 16'h0);
    endtask

    task automatic mem_read(logic exp_en, logic [7:0] exp_d, string tag);
        bus_mreq = 1'b1; bus_rd = 1'b1;
        wait_n(2);
        chk(tag, 16'(dout_en_o), 16'(exp_en));
        if (exp_en) chk(tag, 16'(dout_o), 16'(exp_d));
        bus_mreq = 1'b0; bus_rd = 1'b0;
        wait_n(2);
    endtask

    task automatic fetch(logic [7:0] op);
        bus_m1 = 1'b1; bus_mreq = 1'b1; bus_rd = 1'b1; bus_din = op;
        wait_n(2);
        bus_m1 = 1'b0; bus_mreq = 1'b0; bus_rd = 1'b0;
        wait_n(2);
    endtask

    task automatic t_reset;
        chk("R1 int_o after reset", 16'(int_o), 16'h0);
        chk("R1 dout_en_o after reset", 16'(dout_en_o), 16'h0);
        chk("R1 mem_inhibit_o after reset", 16'(mem_inhibit_o), 16'h0);
        req_i = 8'hFF;
        wait_n(3);
        chk("R1 mask zero blocks requests", 16'(int_o), 16'h0);
        req_i = '0;
        wait_n(2);
    endtask

    task automatic t_config;
        for (int k = 0; k < 8; k++) begin
            logic [15:0] a;
            a = addr_of(k);
            cfg_wr(4'd8, a[15:8]);
            cfg_wr(4'd8, 8'hFF, 1'b0);       // R2: ignored, cs low
            cfg_wr(4'(k), a[7:0]);
        end
        cfg_wr(4'd9, 8'hFE);                 // input 0 disabled
        req_i = 8'h01;
        wait_n(3);
        chk("R3 disabled request ignored", 16'(int_o), 16'h0);
        cfg_wr(4'd9, 8'h00, 1'b0);           // R2: ignored, mask stays FE
        req_i = 8'h02;
        wait_n(3);
        chk("R2 mask write with cs low ignored", 16'(int_o), 16'h1);
        req_i = '0;
        cfg_wr(4'd9, 8'hFF);
        wait_n(3);
    endtask

    task automatic t_basic;
        logic [15:0] a;
        a = addr_of(3);
        req_i = 8'h08;
        wait_n(2);
        chk("R3 int_o raised", 16'(int_o), 16'h1);
        bus_m1 = 1'b1; bus_iorq = 1'b1;
        wait_n(2);
        chk("R4 drive on acknowledge", 16'(dout_en_o), 16'h1);
        chk("R4 opcode", 16'(dout_o), 16'h00CD);
        chk("R6 inhibit set", 16'(mem_inhibit_o), 16'h1);
        chk("R10 int_o low during delivery", 16'(int_o), 16'h0);
        bus_m1 = 1'b0; bus_iorq = 1'b0;
        wait_n(2);
        chk("R4 drive released", 16'(dout_en_o), 16'h0);
        mem_read(1'b1, a[7:0], "R5 low byte first");
        mem_read(1'b1, a[15:8], "R5 high byte second");
        mem_read(1'b0, 8'h00, "R5 third read unanswered");
        chk("R6 inhibit held until fetch", 16'(mem_inhibit_o), 16'h1);
        fetch(8'h00);
        chk("R6 inhibit cleared by fetch", 16'(mem_inhibit_o), 16'h0);
        chk("R8 in-service input held off", 16'(int_o), 16'h0);
        fetch(8'hED);
        fetch(8'h4D);
        chk("R9 return sequence re-arms", 16'(int_o), 16'h1);
        req_i = '0;
        wait_n(2);
    endtask

    task automatic t_priority;
        logic [15:0] a2, a5;
        a2 = addr_of(2);
        a5 = addr_of(5);
        req_i = 8'b1010_0100;
        wait_n(2);
        bus_m1 = 1'b1; bus_iorq = 1'b1;
        wait_n(1);
        req_i = 8'b0000_0001;                // change during delivery
        wait_n(1);
        chk("R4 opcode priority case", 16'(dout_o), 16'h00CD);
        bus_m1 = 1'b0; bus_iorq = 1'b0;
        wait_n(2);
        mem_read(1'b1, a2[7:0], "R7 latched winner low byte");
        mem_read(1'b1, a2[15:8], "R7 latched winner high byte");
        chk("R8 more urgent input interrupts", 16'(int_o), 16'h1);
        fetch(8'h00);
        req_i = 8'b1010_0000;
        wait_n(2);
        chk("R8 less urgent inputs held off", 16'(int_o), 16'h0);
        fetch(8'hED);
        fetch(8'h01);
        chk("R9 broken sequence keeps mark", 16'(int_o), 16'h0);
        fetch(8'hED);
        fetch(8'h4D);
        chk("R9 mark cleared", 16'(int_o), 16'h1);
        ack_cycle(1'b1);
        mem_read(1'b1, a5[7:0], "R7 next winner low byte");
        mem_read(1'b1, a5[15:8], "R7 next winner high byte");
        fetch(8'h00);
        fetch(8'hED);
        fetch(8'h4D);
        req_i = '0;
        wait_n(2);
    endtask

    task automatic t_spurious;
        chk("R11 no request pending", 16'(int_o), 16'h0);
        ack_cycle(1'b0);
        chk("R11 no inhibit", 16'(mem_inhibit_o), 16'h0);
        mem_read(1'b0, 8'h00, "R11 no operand after ignored ack");
    endtask

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(2);
        t_reset();
        t_config();
        t_basic();
        t_priority();
        t_spurious();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule